// File: doc/BRIEF.md
# GPIO Alternate-Function Pin Multiplexer

This block sits between a set of GPIO ports and the on-chip peripherals. Every pin is either a plain software-driven GPIO, controlled by a data and a direction register, or is handed to a peripheral. The handover is set by a per-pin alternate-function enable and a 4-bit per-pin function code. Pad outputs and output enables come out per pin. Peripheral input signals are routed back from the pads. When two ports claim the same peripheral input, the port with the lowest index wins. When two ports claim the same peripheral output, every claiming pin drives it.

A small set of critical pins (a debug port and two interrupt-capable pins) is protected. The debug pins leave reset already assigned to their debug function. All protected pins ignore configuration writes until a port has been unlocked with a fixed 32-bit key and the pin's bit has been set in that port's commit register. Reset restores the protected pins to their special state. Pull-up and pull-down enables are held as register bits only.

Top module: `gpio_mux`

## Requirements
- R1: After reset, every unprotected pin has alternate-function, digital-enable, pull-up, pull-down, direction, data and function code all 0, and every pad output enable is 0 while the peripheral output enables are 0.
- R2: After every reset, port 2 pins 3..0 have alternate-function 1, digital-enable 1, pull-up 1, pull-down 0, function code 1 and commit 0. Port 1 pin 7 and port 3 pin 7 have all configuration bits 0 and commit 0.
- R3: With digital-enable 1 and alternate-function 0, a pad drives its data bit and its output enable equals its direction bit. A DATA read returns the data bit for pins with direction 1, and the pad input for pins with direction 0.
- R4: A pin with digital-enable 0 has pad output 0 and output enable 0. Its pad input reads as 0 through DATA when its direction is 0, and it feeds no peripheral input.
- R5: With digital-enable 1 and alternate-function 1, function code f in 1..NUM_FUNCS on pin i selects peripheral signal s = (f-1)*PINS_PER_PORT + i for pad output and output enable. Code 0 or a code above NUM_FUNCS gives output 0 and enable 0.
- R6: Peripheral input s takes the pad input of the lowest-indexed port whose pin selects s under R5's rule. It is 0 when no pin selects it.
- R7: A peripheral output selected by pins on several ports drives all of those pads at once.
- R8: Each port has a lock register (index 7). Writing UNLOCK_KEY unlocks the port, and any other value locks it. A read returns 1 while locked and 0 while unlocked. All ports are locked after reset.
- R9: The commit register (index 8) reads 1 for every unprotected pin. Its protected bits change only on writes made while that port is unlocked.
- R10: On a protected pin whose commit bit is 0, writes to alternate-function, digital-enable, pull-up, pull-down and function code leave the old value. Data and direction writes still apply.
- R11: Once a protected pin's commit bit is 1, its configuration is writable, including after the port is locked again.
- R12: The register address is {port, index} with the index in the low 4 bits: 0 DATA, 1 DIR, 2 AFSEL, 3 DEN, 4 PULLUP, 5 PULLDOWN, 6 FUNC (pin i at bits 4i+3..4i), 7 LOCK, 8 COMMIT. Other indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous power-on reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address {port, index} |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| padIn | input | NUM_PORTS*PINS_PER_PORT | Pad input, bit port*PINS_PER_PORT+pin |
| padOut | output | NUM_PORTS*PINS_PER_PORT | Pad output value |
| padOe | output | NUM_PORTS*PINS_PER_PORT | Pad output enable |
| periphOut | input | NUM_FUNCS*PINS_PER_PORT | Peripheral output signals |
| periphOe | input | NUM_FUNCS*PINS_PER_PORT | Peripheral output enables |
| periphIn | output | NUM_FUNCS*PINS_PER_PORT | Peripheral input signals routed from pads |

## Verification
The hardest state to reach is a protected pin that has been committed and whose port has since been locked again. Reaching it takes an unlock with the exact key, a commit write, and a relock with a wrong value, all in that order. A directed sequence walks through it and then shows that configuration writes take effect, while a locked commit write does not. Input conflicts need two ports configured on the same pin index with the same code and distinct pad levels. The directed part sets these up explicitly. A long random phase then mixes key writes, commits and routing changes against a behavioural model, compared every clock.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
  localparam int REG_W = 32;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_DATA   = 4'd0,
    REG_DIR    = 4'd1,
    REG_AF     = 4'd2,
    REG_DEN    = 4'd3,
    REG_PUR    = 4'd4,
    REG_PDR    = 4'd5,
    REG_FUNC   = 4'd6,
    REG_LOCK   = 4'd7,
    REG_COMMIT = 4'd8
  } regIdx_e;

  // Write strobes passed from the control to the register datapath.
  typedef struct packed {
    logic             wrData;
    logic             wrDir;
    logic             wrAf;
    logic             wrDen;
    logic             wrPur;
    logic             wrPdr;
    logic             wrFunc;
    logic             wrCommit;
    logic [7:0]       port;
    logic [REG_W-1:0] value;
  } regStrobe_t;
endpackage

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
  import gpio_mux_pkg::*;
#(
  parameter int          NUM_PORTS  = 4,
  parameter int          ADDR_W     = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'h6B1E_C0DE
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  input  logic [31:0]       dpRdData,
  output regStrobe_t        strobe,
  output logic [7:0]        rdPort,
  output logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [31:0]       regRdData
);
  localparam int PORT_W = ADDR_W - IDX_W;

  logic [PORT_W-1:0]    portSel;
  regIdx_e              idx;
  logic                 portValid;
  logic                 wrHit;
  logic [NUM_PORTS-1:0] lockedQ;

  assign portSel   = regAddr[ADDR_W-1:IDX_W];
  assign idx       = regIdx_e'(regAddr[IDX_W-1:0]);
  assign portValid = int'(portSel) < NUM_PORTS;
  assign wrHit     = regWrEn && portValid;

  // Per-port key lock: exact key opens, anything else closes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockedQ <= '1;
    end else if (wrHit && idx == REG_LOCK) begin
      lockedQ[portSel] <= (regWrData != UNLOCK_KEY);
    end
  end

  always_comb begin
    strobe       = '0;
    strobe.port  = 8'(portSel);
    strobe.value = regWrData;
    if (wrHit) begin
      case (idx)
        REG_DATA:   strobe.wrData   = 1'b1;
        REG_DIR:    strobe.wrDir    = 1'b1;
        REG_AF:     strobe.wrAf     = 1'b1;
        REG_DEN:    strobe.wrDen    = 1'b1;
        REG_PUR:    strobe.wrPur    = 1'b1;
        REG_PDR:    strobe.wrPdr    = 1'b1;
        REG_FUNC:   strobe.wrFunc   = 1'b1;
        REG_COMMIT: strobe.wrCommit = !lockedQ[portSel];
        default:    ;
      endcase
    end
  end

  assign rdPort  = 8'(portSel);
  assign rdIdx   = regAddr[IDX_W-1:0];
  assign rdValid = portValid;

  always_comb begin
    if (portValid && idx == REG_LOCK) regRdData = {31'b0, lockedQ[portSel]};
    else                              regRdData = dpRdData;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lockChk
    // R8: the key opens the addressed port on the next cycle
    p_unlock_key_r8: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && int'(regAddr[ADDR_W-1:IDX_W]) == p &&
       regAddr[IDX_W-1:0] == REG_LOCK && regWrData == UNLOCK_KEY)
      |=> (regRdData == 32'd0 || !(int'(regAddr[ADDR_W-1:IDX_W]) == p &&
                                   regAddr[IDX_W-1:0] == REG_LOCK)));
    // R8: any other value closes it again
    p_relock_r8: assert property (@(posedge clk) disable iff (!rstN)
      (regWrEn && int'(regAddr[ADDR_W-1:IDX_W]) == p &&
       regAddr[IDX_W-1:0] == REG_LOCK && regWrData != UNLOCK_KEY)
      |=> lockedQ[p]);
  end
endmodule

// File: rtl/gpio_mux_regs.sv
module gpio_mux_regs
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] PROT_MASK = 32'h800F_8000,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] DBG_MASK  = 32'h000F_0000,
  parameter logic [3:0] DBG_FUNC = 4'h1
) (
  input  logic       clk,
  input  logic       rstN,
  input  regStrobe_t strobe,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] padIn,
  input  logic [7:0]       rdPort,
  input  logic [IDX_W-1:0] rdIdx,
  input  logic             rdValid,
  output logic [31:0]      rdData,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dataQ,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dirQ,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] afQ,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] denQ,
  output logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0][3:0] funcQ
);
  localparam int PINS  = PINS_PER_PORT;
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_PORTS-1:0][PINS-1:0] purQ, pdrQ, commitQ;

  function automatic logic [PINS-1:0] keepLocked(logic [PINS-1:0] oldV,
                                                 logic [PINS-1:0] newV,
                                                 logic [PINS-1:0] open);
    return (newV & open) | (oldV & ~open);
  endfunction

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [PINS-1:0] PROT = PROT_MASK[p*PINS +: PINS];
    localparam logic [PINS-1:0] DBG  = DBG_MASK[p*PINS +: PINS];

    logic [PINS-1:0] dataR, dirR, afR, denR, purR, pdrR, commitR;
    logic [PINS-1:0][3:0] funcR;
    logic [PINS-1:0] openMask;
    logic            hit;

    assign openMask = ~PROT | commitR;
    assign hit      = (strobe.port == 8'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataR   <= '0;
        dirR    <= '0;
        afR     <= DBG;
        denR    <= DBG;
        purR    <= DBG;
        pdrR    <= '0;
        commitR <= ~PROT;
        for (int i = 0; i < PINS; i++) funcR[i] <= DBG[i] ? DBG_FUNC : 4'h0;
      end else if (hit) begin
        if (strobe.wrData) dataR <= strobe.value[PINS-1:0];
        if (strobe.wrDir)  dirR  <= strobe.value[PINS-1:0];
        if (strobe.wrAf)   afR   <= keepLocked(afR,  strobe.value[PINS-1:0], openMask);
        if (strobe.wrDen)  denR  <= keepLocked(denR, strobe.value[PINS-1:0], openMask);
        if (strobe.wrPur)  purR  <= keepLocked(purR, strobe.value[PINS-1:0], openMask);
        if (strobe.wrPdr)  pdrR  <= keepLocked(pdrR, strobe.value[PINS-1:0], openMask);
        if (strobe.wrCommit) commitR <= strobe.value[PINS-1:0] | ~PROT;
        if (strobe.wrFunc) begin
          for (int i = 0; i < PINS; i++)
            if (openMask[i]) funcR[i] <= strobe.value[4*i +: 4];
        end
      end
    end

    assign dataQ[p]   = dataR;
    assign dirQ[p]    = dirR;
    assign afQ[p]     = afR;
    assign denQ[p]    = denR;
    assign purQ[p]    = purR;
    assign pdrQ[p]    = pdrR;
    assign commitQ[p] = commitR;
    assign funcQ[p]   = funcR;

    for (genvar i = 0; i < PINS; i++) begin : g_guard
      if (PROT[i]) begin : g_prot
        // R10: an uncommitted protected pin keeps its configuration
        p_locked_pin_r10: assert property (@(posedge clk) disable iff (!rstN)
          !commitR[i] |=> ($stable(afR[i]) && $stable(denR[i]) && $stable(purR[i])
                           && $stable(pdrR[i]) && $stable(funcR[i])));
      end
    end
  end

  logic [PSEL_W-1:0] rp;
  assign rp = rdPort[PSEL_W-1:0];

  always_comb begin
    rdData = '0;
    if (rdValid) begin
      case (rdIdx)
        REG_DATA:
          for (int i = 0; i < PINS; i++)
            rdData[i] = dirQ[rp][i] ? dataQ[rp][i] : (denQ[rp][i] & padIn[rp][i]);
        REG_DIR:    rdData[PINS-1:0] = dirQ[rp];
        REG_AF:     rdData[PINS-1:0] = afQ[rp];
        REG_DEN:    rdData[PINS-1:0] = denQ[rp];
        REG_PUR:    rdData[PINS-1:0] = purQ[rp];
        REG_PDR:    rdData[PINS-1:0] = pdrQ[rp];
        REG_COMMIT: rdData[PINS-1:0] = commitQ[rp];
        REG_FUNC:
          for (int i = 0; i < PINS; i++) rdData[4*i +: 4] = funcQ[rp][i];
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mux_route.sv
module gpio_mux_route #(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_FUNCS     = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dataQ,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] dirQ,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] afQ,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] denQ,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0][3:0] funcQ,
  input  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] padIn,
  input  logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphOut,
  input  logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphOe,
  output logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphIn,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] padOut,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] padOe
);
  localparam int PINS     = PINS_PER_PORT;
  localparam int NUM_SIGS = NUM_FUNCS * PINS;

  // Pad side: GPIO, peripheral or quiet.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_padPort
    for (genvar i = 0; i < PINS; i++) begin : g_pad
      logic outV, oeV;
      always_comb begin
        outV = 1'b0;
        oeV  = 1'b0;
        if (denQ[p][i]) begin
          if (!afQ[p][i]) begin
            outV = dataQ[p][i];
            oeV  = dirQ[p][i];
          end else if (funcQ[p][i] != 4'h0 && int'(funcQ[p][i]) <= NUM_FUNCS) begin
            outV = periphOut[(int'(funcQ[p][i]) - 1) * PINS + i];
            oeV  = periphOe[(int'(funcQ[p][i]) - 1) * PINS + i];
          end
        end
      end
      assign padOut[p*PINS + i] = outV;
      assign padOe[p*PINS + i]  = oeV;

      // R5: an out-of-range code never enables the pad
      p_unmapped_r5: assert property (@(posedge clk) disable iff (!rstN)
        (afQ[p][i] && (funcQ[p][i] == 4'h0 || int'(funcQ[p][i]) > NUM_FUNCS))
        |-> !padOe[p*PINS + i]);
    end
  end

  // Peripheral side: lowest port index wins a conflict.
  for (genvar s = 0; s < NUM_SIGS; s++) begin : g_in
    localparam int FUNC = s / PINS + 1;
    localparam int PIN  = s % PINS;
    logic inV;
    always_comb begin
      inV = 1'b0;
      for (int q = NUM_PORTS - 1; q >= 0; q--)
        if (denQ[q][PIN] && afQ[q][PIN] && funcQ[q][PIN] == 4'(FUNC))
          inV = padIn[q][PIN];
    end
    assign periphIn[s] = inV;
  end
endmodule

// File: rtl/gpio_mux.sv
module gpio_mux
  import gpio_mux_pkg::*;
#(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int NUM_FUNCS     = 3,
  parameter int ADDR_W        = 6,
  parameter logic [31:0] UNLOCK_KEY = 32'h6B1E_C0DE,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] PROT_MASK = 32'h800F_8000,
  parameter logic [NUM_PORTS*PINS_PER_PORT-1:0] DBG_MASK  = 32'h000F_0000,
  parameter logic [3:0] DBG_FUNC = 4'h1
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic [NUM_PORTS*PINS_PER_PORT-1:0] padIn,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] padOut,
  output logic [NUM_PORTS*PINS_PER_PORT-1:0] padOe,
  input  logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphOut,
  input  logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphOe,
  output logic [NUM_FUNCS*PINS_PER_PORT-1:0] periphIn
);
  localparam int NUM_PINS = NUM_PORTS * PINS_PER_PORT;

  regStrobe_t       strobe;
  logic [7:0]       rdPort;
  logic [IDX_W-1:0] rdIdx;
  logic             rdValid;
  logic [31:0]      dpRdData;
  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0] padInArr, dataQ, dirQ, afQ, denQ;
  logic [NUM_PORTS-1:0][PINS_PER_PORT-1:0][3:0] funcQ;
  logic [NUM_PINS-1:0] denFlat;

  assign padInArr = padIn;
  assign denFlat  = denQ;

  gpio_mux_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .dpRdData(dpRdData), .strobe(strobe),
    .rdPort(rdPort), .rdIdx(rdIdx), .rdValid(rdValid), .regRdData(regRdData)
  );

  gpio_mux_regs #(
    .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT),
    .PROT_MASK(PROT_MASK), .DBG_MASK(DBG_MASK), .DBG_FUNC(DBG_FUNC)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .padIn(padInArr),
    .rdPort(rdPort), .rdIdx(rdIdx), .rdValid(rdValid), .rdData(dpRdData),
    .dataQ(dataQ), .dirQ(dirQ), .afQ(afQ), .denQ(denQ), .funcQ(funcQ)
  );

  gpio_mux_route #(
    .NUM_PORTS(NUM_PORTS), .PINS_PER_PORT(PINS_PER_PORT), .NUM_FUNCS(NUM_FUNCS)
  ) uRoute (
    .clk(clk), .rstN(rstN), .dataQ(dataQ), .dirQ(dirQ), .afQ(afQ),
    .denQ(denQ), .funcQ(funcQ), .padIn(padInArr), .periphOut(periphOut),
    .periphOe(periphOe), .periphIn(periphIn), .padOut(padOut), .padOe(padOe)
  );

  // R4: a digitally disabled pin is silent at the pad
  p_den_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & ~denFlat) == '0);
endmodule

// File: tb/gpio_mux_test.sv
module gpio_mux_test;
  localparam int NP = 4, PP = 8, NF = 3, NS = NF * PP;
  localparam logic [31:0] KEY = 32'h6B1E_C0DE;

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0, padIn = '0;
  logic [NS-1:0] periphOut = '0, periphOe = '0;
  wire  [31:0] regRdData, padOut, padOe;
  wire  [NS-1:0] periphIn;

  int checks = 0, errs = 0;

  gpio_mux uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .periphOut(periphOut),
    .periphOe(periphOe), .periphIn(periphIn)
  );

  always #10 clk = ~clk;

  // Behavioural reference state
  bit mData[NP][PP], mDir[NP][PP], mAf[NP][PP], mDen[NP][PP];
  bit mPur[NP][PP], mPdr[NP][PP], mCommit[NP][PP];
  int mFunc[NP][PP];
  bit mLocked[NP];

  function automatic bit isProt(int p, int i);
    return (p == 1 && i == 7) || (p == 2 && i < 4) || (p == 3 && i == 7);
  endfunction

  function automatic bit isDbg(int p, int i);
    return p == 2 && i < 4;
  endfunction

  task automatic mReset();
    for (int p = 0; p < NP; p++) begin
      mLocked[p] = 1;
      for (int i = 0; i < PP; i++) begin
        mData[p][i] = 0; mDir[p][i] = 0; mPdr[p][i] = 0;
        mAf[p][i] = isDbg(p, i); mDen[p][i] = isDbg(p, i); mPur[p][i] = isDbg(p, i);
        mFunc[p][i] = isDbg(p, i) ? 1 : 0;
        mCommit[p][i] = !isProt(p, i);
      end
    end
  endtask

  task automatic mWrite(int a, logic [31:0] d);
    int p = a / 16, idx = a % 16;
    bit open;
    for (int i = 0; i < PP; i++) begin
      open = !isProt(p, i) || mCommit[p][i];
      case (idx)
        0: mData[p][i] = d[i];
        1: mDir[p][i] = d[i];
        2: if (open) mAf[p][i] = d[i];
        3: if (open) mDen[p][i] = d[i];
        4: if (open) mPur[p][i] = d[i];
        5: if (open) mPdr[p][i] = d[i];
        6: if (open) mFunc[p][i] = int'(d[4*i +: 4]);
        8: if (!mLocked[p] && isProt(p, i)) mCommit[p][i] = d[i];
        default: ;
      endcase
    end
    if (idx == 7) mLocked[p] = (d != KEY);
  endtask

  function automatic logic [31:0] mRead(int a);
    int p = a / 16, idx = a % 16;
    logic [31:0] r = '0;
    for (int i = 0; i < PP; i++) begin
      case (idx)
        0: r[i] = mDir[p][i] ? mData[p][i] : (mDen[p][i] & padIn[p*PP+i]);
        1: r[i] = mDir[p][i];
        2: r[i] = mAf[p][i];
        3: r[i] = mDen[p][i];
        4: r[i] = mPur[p][i];
        5: r[i] = mPdr[p][i];
        6: r[4*i +: 4] = 4'(mFunc[p][i]);
        8: r[i] = mCommit[p][i];
        default: ;
      endcase
    end
    if (idx == 7) r = {31'b0, mLocked[p]};
    return r;
  endfunction

  function automatic logic [63:0] mPads();   // {oe, out}
    logic [31:0] o = '0, e = '0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < PP; i++)
        if (mDen[p][i]) begin
          if (!mAf[p][i]) begin
            o[p*PP+i] = mData[p][i]; e[p*PP+i] = mDir[p][i];
          end else if (mFunc[p][i] >= 1 && mFunc[p][i] <= NF) begin
            o[p*PP+i] = periphOut[(mFunc[p][i]-1)*PP+i];
            e[p*PP+i] = periphOe[(mFunc[p][i]-1)*PP+i];
          end
        end
    return {e, o};
  endfunction

  function automatic logic [NS-1:0] mPeriph();
    logic [NS-1:0] v = '0;
    for (int s = 0; s < NS; s++) begin
      bit found = 0;
      for (int q = 0; q < NP; q++)
        if (!found && mDen[q][s%PP] && mAf[q][s%PP] && mFunc[q][s%PP] == s/PP + 1) begin
          v[s] = padIn[q*PP + s%PP];
          found = 1;
        end
    end
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Model step and full comparison on every clock
  always @(posedge clk) begin
    logic [63:0] pads;
    if (!rstN) mReset();
    else if (regWrEn) mWrite(int'(regAddr), regWrData);
    #5;
    pads = mPads();
    check("R3/R4/R5/R7 padOut model", padOut, pads[31:0]);
    check("R3/R4/R5/R7 padOe model", padOe, pads[63:32]);
    check("R6 periphIn model", 32'(periphIn), 32'(mPeriph()));
    check("R12 read model", regRdData, mRead(int'(regAddr)));
  end

  function automatic logic [5:0] A(int p, int idx);
    return 6'(p * 16 + idx);
  endfunction

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdExp(string req, logic [5:0] a, logic [31:0] exp);
    @(negedge clk);
    regWrEn = 0; regAddr = a;
    #2 check(req, regRdData, exp);
  endtask

  task automatic drive(logic [31:0] pin, logic [NS-1:0] po, logic [NS-1:0] poe);
    @(negedge clk);
    padIn = pin; periphOut = po; periphOe = poe;
    #2;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0;
    repeat (2) @(negedge clk);
    rstN = 1;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset of plain pins
    rdExp("R1 af p0", A(0, 2), 32'h0);
    rdExp("R1 den p0", A(0, 3), 32'h0);
    rdExp("R1 func p0", A(0, 6), 32'h0);
    rdExp("R1 dir p3", A(3, 1), 32'h0);
    #1 check("R1 padOe", padOe, 32'h0);
    // R2 protected reset
    rdExp("R2 af p2", A(2, 2), 32'h0F);
    rdExp("R2 den p2", A(2, 3), 32'h0F);
    rdExp("R2 pur p2", A(2, 4), 32'h0F);
    rdExp("R2 pdr p2", A(2, 5), 32'h0);
    rdExp("R2 func p2", A(2, 6), 32'h0000_1111);
    rdExp("R2 af p1", A(1, 2), 32'h0);
    rdExp("R9 commit p2", A(2, 8), 32'hF0);
    rdExp("R9 commit p1", A(1, 8), 32'h7F);
    rdExp("R9 commit p0", A(0, 8), 32'hFF);
    rdExp("R8 lock reset", A(0, 7), 32'h1);
    rdExp("R12 unused index", A(0, 12), 32'h0);
    drive(32'h0, 24'h00000A, 24'h00000F);
    check("R2 debug pads out", 32'(padOut[19:16]), 32'hA);
    check("R2 debug pads oe", 32'(padOe[19:16]), 32'hF);

    // R10 protected pins ignore configuration while uncommitted
    wr(A(2, 2), 32'h0);
    rdExp("R10 af kept", A(2, 2), 32'h0F);
    wr(A(2, 6), 32'h0);
    rdExp("R10 func kept", A(2, 6), 32'h0000_1111);
    wr(A(1, 3), 32'hFF);
    rdExp("R10 den p1", A(1, 3), 32'h7F);
    wr(A(1, 1), 32'h80);
    wr(A(1, 0), 32'h80);
    rdExp("R10 data still writable", A(1, 0), 32'h80);

    // R3 GPIO mode
    wr(A(0, 3), 32'hFF);
    wr(A(0, 1), 32'h0F);
    wr(A(0, 0), 32'hA5);
    drive(32'h3C, 24'h0, 24'h0);
    check("R3 padOut", 32'(padOut[7:0]), 32'hA5);
    check("R3 padOe", 32'(padOe[7:0]), 32'h0F);
    rdExp("R3 data read", A(0, 0), 32'h35);
    // R4 digital enable off
    wr(A(0, 3), 32'h3F);
    drive(32'hFF, 24'h0, 24'h0);
    check("R4 padOut", 32'(padOut[7:0]), 32'h25);
    check("R4 padOe", 32'(padOe[7:0]), 32'h0F);
    rdExp("R4 data read", A(0, 0), 32'h35);

    // R5 function selection
    wr(A(0, 3), 32'hFF);
    wr(A(0, 2), 32'hFF);
    wr(A(0, 6), 32'h0004_0321);
    drive(32'h0, 24'h040201, 24'hFFFFFF);
    check("R5 padOut", 32'(padOut[7:0]), 32'h07);
    check("R5 padOe", 32'(padOe[7:0]), 32'h07);

    // R6 / R7 conflicts on signal 18 (code 3, pin 2)
    wr(A(3, 3), 32'h04);
    wr(A(3, 2), 32'h04);
    wr(A(3, 6), 32'h0000_0300);
    drive(32'h0000_0004, 24'h040000, 24'h040000);
    check("R6 lowest port wins high", 32'(periphIn[18]), 32'h1);
    check("R7 fan-out p0", 32'(padOut[2]), 32'h1);
    check("R7 fan-out p3", 32'(padOut[26]), 32'h1);
    check("R7 fan-out oe", 32'({padOe[26], padOe[2]}), 32'h3);
    drive(32'h0400_0000, 24'h0, 24'h0);
    check("R6 lowest port wins low", 32'(periphIn[18]), 32'h0);
    check("R6 unmapped signal", 32'(periphIn[5]), 32'h0);
    wr(A(0, 2), 32'hFB);
    drive(32'h0400_0000, 24'h0, 24'h0);
    check("R6 fallback port3", 32'(periphIn[18]), 32'h1);

    // R8 / R9 / R11 lock and commit sequence
    wr(A(2, 7), 32'h1234_5678);
    rdExp("R8 wrong key", A(2, 7), 32'h1);
    wr(A(2, 8), 32'h0F);
    rdExp("R9 commit while locked", A(2, 8), 32'hF0);
    wr(A(2, 7), KEY);
    rdExp("R8 unlocked", A(2, 7), 32'h0);
    rdExp("R8 other port locked", A(0, 7), 32'h1);
    wr(A(2, 8), 32'h0F);
    rdExp("R9 commit set", A(2, 8), 32'hFF);
    wr(A(2, 7), 32'h0);
    rdExp("R8 relocked", A(2, 7), 32'h1);
    wr(A(2, 2), 32'h0);
    rdExp("R11 af writable after relock", A(2, 2), 32'h0);
    wr(A(2, 8), 32'h0);
    rdExp("R9 commit held while locked", A(2, 8), 32'hFF);

    // R2 reset restores protected pins
    doReset();
    rdExp("R2 af after reset", A(2, 2), 32'h0F);
    rdExp("R2 commit after reset", A(2, 8), 32'hF0);
    rdExp("R8 lock after reset", A(2, 7), 32'h1);

    // Random phase against the model
    for (int n = 0; n < 1500; n++) begin
      logic [5:0] a = 6'($urandom);
      logic [31:0] d = $urandom;
      if (a[3:0] == 4'd7 && ($urandom % 2) == 0) d = KEY;
      if (a[3:0] == 4'd6) d = d & 32'h3333_3333;
      @(negedge clk);
      regWrEn = ($urandom % 3) != 0;
      regAddr = a; regWrData = d;
      padIn = $urandom;
      periphOut = NS'($urandom); periphOe = NS'($urandom);
    end
    @(negedge clk);
    regWrEn = 0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule